// File: doc/BRIEF.md
# Triangle facing, reject and clip-route stage

This stage sits between primitive assembly and the clipper of a rasterising front end. It accepts one screen-space triangle per valid/ready handshake. Each vertex carries signed fixed-point X and Y and a depth value Z. Every triangle ends up in one of three outcomes: it is dropped, it goes forward on the fast path, or it goes forward marked for clipping with a mask of the planes it crosses.

First comes a facing test on the sign of twice the signed area. A per-triangle winding input selects which sign counts as front. Each vertex is then compared against six planes: the X and Y limits of the viewport and the near and far depth limits. Back-facing triangles are dropped, and so are triangles that lie wholly beyond any single plane. The facing test is applied first, so a back-facing triangle never reaches the clip path.

Surviving triangles leave in their arrival order from a single output port. A clip flag and a six-bit plane mask tell the two kinds apart. The stage has three registers in series and holds everything in place when the consumer stalls.

Top module: `prim_classify`

## Requirements
- R1: With area = (x1-x0)(y2-y0) - (x2-x0)(y1-y0), a triangle is front-facing when area > 0 and `ccw_front_i`=1, or when area < 0 and `ccw_front_i`=0. All other triangles, including zero area, produce no output. `ccw_front_i` is sampled with the triangle it accompanies.
- R2: Per-vertex plane code bits use strict comparisons: bit0 x<X_MIN, bit1 x>X_MAX, bit2 y<Y_MIN, bit3 y>Y_MAX, bit4 z<Z_NEAR, bit5 z>Z_FAR. The defaults are X 0..1023, Y 0..767 and Z 0..4095, and a vertex exactly on a limit is inside.
- R3: A front-facing triangle whose three vertex codes share a set bit produces no output.
- R4: A front-facing triangle whose three vertex codes are all zero is emitted with `out_clip_o`=0, `out_planes_o`=0 and its vertices unchanged.
- R5: Any other front-facing triangle is emitted with `out_clip_o`=1 and with `out_planes_o` equal to the OR of the three vertex codes. Its vertices are unchanged.
- R6: With no stall, a triangle accepted at clock edge k is presented on the output right after edge k+2, and not earlier.
- R7: While `out_valid_o`=1 and `out_ready_i`=0, `in_ready_o` is 0 and every output holds. No triangle is lost or reordered.
- R8: With `out_ready_i` held at 1, `in_ready_o` stays 1, and a triangle can be accepted and emitted on every cycle.
- R9: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ccw_front_i | input | 1 | 1: counter-clockwise (positive area) is front |
| in_valid_i | input | 1 | Input triangle valid |
| in_ready_o | output | 1 | Stage can accept a triangle |
| in_x_i | input | 3x16 | Vertex X, signed, vertex n in slice n |
| in_y_i | input | 3x16 | Vertex Y, signed |
| in_z_i | input | 3x16 | Vertex Z, signed |
| out_valid_o | output | 1 | Output triangle valid |
| out_ready_i | input | 1 | Consumer accepts output |
| out_clip_o | output | 1 | 1: crosses a plane, route to clipper |
| out_planes_o | output | 6 | Crossed-plane mask (R2 bit order) |
| out_x_o | output | 3x16 | Output vertex X |
| out_y_o | output | 3x16 | Output vertex Y |
| out_z_o | output | 3x16 | Output vertex Z |

## Verification
A corrupted area product or a lost winding bit appears two edges after acceptance, in one of two ways: a triangle shows up that should have been dropped, or an expected triangle never appears. The bench spots the gap at the first output slot it samples. A wrong plane code appears on the same output beat, either as a clip flag or mask that disagrees with the vertices it travels with, or as a fast-path triangle with a vertex off screen. A flaw in the stall logic shows as an output that changes while it is held, or as a gap or reordering in the arrival sequence, which the bench detects at the next handshake.

// File: rtl/prim_classify_pkg.sv
package prim_classify_pkg;
  localparam int COORD_W = 16;
  localparam int Z_W     = 16;
  localparam int NVERT   = 3;
  localparam int NPLANE  = 6;
  localparam int DIFF_W  = COORD_W + 1;
  localparam int PROD_W  = 2 * DIFF_W;
  localparam int AREA_W  = PROD_W + 1;

  localparam int PL_XLO = 0;
  localparam int PL_XHI = 1;
  localparam int PL_YLO = 2;
  localparam int PL_YHI = 3;
  localparam int PL_ZLO = 4;
  localparam int PL_ZHI = 5;

  typedef logic [NPLANE-1:0] outcode_t;

  typedef struct packed {
    logic [NVERT-1:0][COORD_W-1:0] x;
    logic [NVERT-1:0][COORD_W-1:0] y;
    logic [NVERT-1:0][Z_W-1:0]     z;
  } tri_t;

  function automatic logic signed [DIFF_W-1:0] sdiff(input logic [COORD_W-1:0] a,
                                                     input logic [COORD_W-1:0] b);
    return {a[COORD_W-1], a} - {b[COORD_W-1], b};
  endfunction
endpackage

// File: rtl/pc_outcode.sv
module pc_outcode
  import prim_classify_pkg::*;
#(
  parameter int X_MIN  = 0,
  parameter int X_MAX  = 1023,
  parameter int Y_MIN  = 0,
  parameter int Y_MAX  = 767,
  parameter int Z_NEAR = 0,
  parameter int Z_FAR  = 4095
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [Z_W-1:0]     z_i,
  output outcode_t           code_o
);
  localparam logic signed [COORD_W-1:0] XLO = COORD_W'(X_MIN);
  localparam logic signed [COORD_W-1:0] XHI = COORD_W'(X_MAX);
  localparam logic signed [COORD_W-1:0] YLO = COORD_W'(Y_MIN);
  localparam logic signed [COORD_W-1:0] YHI = COORD_W'(Y_MAX);
  localparam logic signed [Z_W-1:0]     ZLO = Z_W'(Z_NEAR);
  localparam logic signed [Z_W-1:0]     ZHI = Z_W'(Z_FAR);

  logic signed [COORD_W-1:0] xs, ys;
  logic signed [Z_W-1:0]     zs;

  assign xs = x_i;
  assign ys = y_i;
  assign zs = z_i;

  always_comb begin
    code_o         = '0;
    code_o[PL_XLO] = xs < XLO;
    code_o[PL_XHI] = xs > XHI;
    code_o[PL_YLO] = ys < YLO;
    code_o[PL_YHI] = ys > YHI;
    code_o[PL_ZLO] = zs < ZLO;
    code_o[PL_ZHI] = zs > ZHI;
  end
endmodule

// File: rtl/pc_edge_stage.sv
module pc_edge_stage
  import prim_classify_pkg::*;
#(
  parameter int X_MIN  = 0,
  parameter int X_MAX  = 1023,
  parameter int Y_MIN  = 0,
  parameter int Y_MAX  = 767,
  parameter int Z_NEAR = 0,
  parameter int Z_FAR  = 4095
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     valid_i,
  input  logic                     ccw_i,
  input  tri_t                     tri_i,
  output logic                     valid_o,
  output logic                     ccw_o,
  output tri_t                     tri_o,
  output logic signed [PROD_W-1:0] prod_a_o,
  output logic signed [PROD_W-1:0] prod_b_o,
  output outcode_t [NVERT-1:0]     oc_o
);
  logic signed [DIFF_W-1:0] dx1, dy2, dx2, dy1;
  logic signed [PROD_W-1:0] pa, pb;
  outcode_t [NVERT-1:0]     oc_c;

  assign dx1 = sdiff(tri_i.x[1], tri_i.x[0]);
  assign dy2 = sdiff(tri_i.y[2], tri_i.y[0]);
  assign dx2 = sdiff(tri_i.x[2], tri_i.x[0]);
  assign dy1 = sdiff(tri_i.y[1], tri_i.y[0]);
  assign pa  = PROD_W'(dx1) * PROD_W'(dy2);
  assign pb  = PROD_W'(dx2) * PROD_W'(dy1);

  for (genvar v = 0; v < NVERT; v++) begin : g_oc
    pc_outcode #(
      .X_MIN(X_MIN), .X_MAX(X_MAX), .Y_MIN(Y_MIN),
      .Y_MAX(Y_MAX), .Z_NEAR(Z_NEAR), .Z_FAR(Z_FAR)
    ) i_oc (
      .x_i   (tri_i.x[v]),
      .y_i   (tri_i.y[v]),
      .z_i   (tri_i.z[v]),
      .code_o(oc_c[v])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else if (en_i) valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (en_i && valid_i) begin
      ccw_o    <= ccw_i;
      tri_o    <= tri_i;
      prod_a_o <= pa;
      prod_b_o <= pb;
      oc_o     <= oc_c;
    end
  end
endmodule

// File: rtl/pc_decide_stage.sv
module pc_decide_stage
  import prim_classify_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     valid_i,
  input  logic                     ccw_i,
  input  tri_t                     tri_i,
  input  logic signed [PROD_W-1:0] prod_a_i,
  input  logic signed [PROD_W-1:0] prod_b_i,
  input  outcode_t [NVERT-1:0]     oc_i,
  output logic                     valid_o,
  output logic                     clip_o,
  output outcode_t                 planes_o,
  output tri_t                     tri_o
);
  logic signed [AREA_W-1:0] area;
  logic     area_pos, area_neg, front, keep;
  outcode_t oc_and, oc_or;

  assign area     = AREA_W'(prod_a_i) - AREA_W'(prod_b_i);
  assign area_neg = area[AREA_W-1];
  assign area_pos = !area[AREA_W-1] && (area != '0);
  assign front    = ccw_i ? area_pos : area_neg;

  always_comb begin
    oc_and = '1;
    oc_or  = '0;
    for (int v = 0; v < NVERT; v++) begin
      oc_and = oc_and & oc_i[v];
      oc_or  = oc_or | oc_i[v];
    end
  end

  // facing first: back faces never reach the plane routing
  assign keep = valid_i && front && (oc_and == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else if (en_i) valid_o <= keep;
  end

  always_ff @(posedge clk_i) begin
    if (en_i && keep) begin
      clip_o   <= (oc_or != '0);
      planes_o <= oc_or;
      tri_o    <= tri_i;
    end
  end
endmodule

// File: rtl/prim_classify.sv
module prim_classify
  import prim_classify_pkg::*;
#(
  parameter int X_MIN  = 0,
  parameter int X_MAX  = 1023,
  parameter int Y_MIN  = 0,
  parameter int Y_MAX  = 767,
  parameter int Z_NEAR = 0,
  parameter int Z_FAR  = 4095
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            ccw_front_i,
  input  logic                            in_valid_i,
  output logic                            in_ready_o,
  input  logic [NVERT-1:0][COORD_W-1:0]   in_x_i,
  input  logic [NVERT-1:0][COORD_W-1:0]   in_y_i,
  input  logic [NVERT-1:0][Z_W-1:0]       in_z_i,
  output logic                            out_valid_o,
  input  logic                            out_ready_i,
  output logic                            out_clip_o,
  output logic [NPLANE-1:0]               out_planes_o,
  output logic [NVERT-1:0][COORD_W-1:0]   out_x_o,
  output logic [NVERT-1:0][COORD_W-1:0]   out_y_o,
  output logic [NVERT-1:0][Z_W-1:0]       out_z_o
);
  logic en;
  tri_t in_tri, s1_tri, s2_tri, out_tri;
  logic s1_valid, s1_ccw, s2_valid, s2_clip;
  logic signed [PROD_W-1:0] s1_pa, s1_pb;
  outcode_t [NVERT-1:0] s1_oc;
  outcode_t s2_planes;

  // whole pipe advances together; bubbles are cheap at one triangle per cycle
  assign en         = !out_valid_o || out_ready_i;
  assign in_ready_o = en;

  assign in_tri.x = in_x_i;
  assign in_tri.y = in_y_i;
  assign in_tri.z = in_z_i;

  pc_edge_stage #(
    .X_MIN(X_MIN), .X_MAX(X_MAX), .Y_MIN(Y_MIN),
    .Y_MAX(Y_MAX), .Z_NEAR(Z_NEAR), .Z_FAR(Z_FAR)
  ) i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .valid_i (in_valid_i),
    .ccw_i   (ccw_front_i),
    .tri_i   (in_tri),
    .valid_o (s1_valid),
    .ccw_o   (s1_ccw),
    .tri_o   (s1_tri),
    .prod_a_o(s1_pa),
    .prod_b_o(s1_pb),
    .oc_o    (s1_oc)
  );

  pc_decide_stage i_decide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .valid_i (s1_valid),
    .ccw_i   (s1_ccw),
    .tri_i   (s1_tri),
    .prod_a_i(s1_pa),
    .prod_b_i(s1_pb),
    .oc_i    (s1_oc),
    .valid_o (s2_valid),
    .clip_o  (s2_clip),
    .planes_o(s2_planes),
    .tri_o   (s2_tri)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else if (en) out_valid_o <= s2_valid;
  end

  always_ff @(posedge clk_i) begin
    if (en && s2_valid) begin
      out_clip_o   <= s2_clip;
      out_planes_o <= s2_planes;
      out_tri      <= s2_tri;
    end
  end

  assign out_x_o = out_tri.x;
  assign out_y_o = out_tri.y;
  assign out_z_o = out_tri.z;
endmodule

// File: rtl/prim_classify_chk.sv
module prim_classify_chk
  import prim_classify_pkg::*;
#(
  parameter int X_MIN  = 0,
  parameter int X_MAX  = 1023,
  parameter int Y_MIN  = 0,
  parameter int Y_MAX  = 767,
  parameter int Z_NEAR = 0,
  parameter int Z_FAR  = 4095
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          in_ready_o,
  input logic                          out_valid_o,
  input logic                          out_ready_i,
  input logic                          out_clip_o,
  input logic [NPLANE-1:0]             out_planes_o,
  input logic [NVERT-1:0][COORD_W-1:0] out_x_o,
  input logic [NVERT-1:0][COORD_W-1:0] out_y_o,
  input logic [NVERT-1:0][Z_W-1:0]     out_z_o
);
  outcode_t [NVERT-1:0] ocv;
  outcode_t oc_or, oc_and;

  for (genvar v = 0; v < NVERT; v++) begin : g_oc
    pc_outcode #(
      .X_MIN(X_MIN), .X_MAX(X_MAX), .Y_MIN(Y_MIN),
      .Y_MAX(Y_MAX), .Z_NEAR(Z_NEAR), .Z_FAR(Z_FAR)
    ) i_oc (
      .x_i(out_x_o[v]), .y_i(out_y_o[v]), .z_i(out_z_o[v]), .code_o(ocv[v])
    );
  end

  always_comb begin
    oc_or  = '0;
    oc_and = '1;
    for (int v = 0; v < NVERT; v++) begin
      oc_or  = oc_or | ocv[v];
      oc_and = oc_and & ocv[v];
    end
  end

  AST_NO_SHARED_PLANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> oc_and == '0); // R3
  AST_FAST_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_clip_o |-> oc_or == '0 && out_planes_o == '0); // R4
  AST_CLIP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_clip_o |-> out_planes_o == oc_or && oc_or != '0); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_clip_o) &&
      $stable(out_planes_o) && $stable(out_x_o) && $stable(out_y_o) && $stable(out_z_o)); // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R7
  AST_FLOW_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o); // R8
endmodule

bind prim_classify prim_classify_chk #(
  .X_MIN(X_MIN), .X_MAX(X_MAX), .Y_MIN(Y_MIN),
  .Y_MAX(Y_MAX), .Z_NEAR(Z_NEAR), .Z_FAR(Z_FAR)
) i_prim_classify_chk (.*);

// File: tb/test_prim_classify.sv
module test_prim_classify;
  import prim_classify_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ccw_front_i = 1'b1;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [NVERT-1:0][COORD_W-1:0] in_x_i = '0, in_y_i = '0;
  logic [NVERT-1:0][Z_W-1:0]     in_z_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b1;
  logic out_clip_o;
  logic [NPLANE-1:0] out_planes_o;
  logic [NVERT-1:0][COORD_W-1:0] out_x_o, out_y_o;
  logic [NVERT-1:0][Z_W-1:0]     out_z_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prim_classify i_prim_classify (
    .clk_i(clk), .rst_ni(rst_ni), .ccw_front_i(ccw_front_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_x_i(in_x_i), .in_y_i(in_y_i), .in_z_i(in_z_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_clip_o(out_clip_o), .out_planes_o(out_planes_o),
    .out_x_o(out_x_o), .out_y_o(out_y_o), .out_z_o(out_z_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic tri_t mk(input int x0, input int y0, input int x1, input int y1,
                              input int x2, input int y2, input int z0, input int z1,
                              input int z2);
    tri_t t;
    t.x[0] = COORD_W'(x0); t.y[0] = COORD_W'(y0); t.z[0] = Z_W'(z0);
    t.x[1] = COORD_W'(x1); t.y[1] = COORD_W'(y1); t.z[1] = Z_W'(z1);
    t.x[2] = COORD_W'(x2); t.y[2] = COORD_W'(y2); t.z[2] = Z_W'(z2);
    return t;
  endfunction

  function automatic logic [5:0] vcode(input int x, input int y, input int z);
    logic [5:0] c;
    c[0] = x < 0; c[1] = x > 1023; c[2] = y < 0;
    c[3] = y > 767; c[4] = z < 0; c[5] = z > 4095;
    return c;
  endfunction

  // spec model from R1..R5
  task automatic spec(input tri_t t, input bit ccw, output bit keep, output bit clip,
                      output logic [5:0] mask);
    longint x0, y0, x1, y1, x2, y2, area;
    logic [5:0] a, o, c;
    x0 = longint'($signed(t.x[0])); y0 = longint'($signed(t.y[0]));
    x1 = longint'($signed(t.x[1])); y1 = longint'($signed(t.y[1]));
    x2 = longint'($signed(t.x[2])); y2 = longint'($signed(t.y[2]));
    area = (x1 - x0) * (y2 - y0) - (x2 - x0) * (y1 - y0);
    a = '1; o = '0;
    for (int v = 0; v < 3; v++) begin
      c = vcode(int'($signed(t.x[v])), int'($signed(t.y[v])), int'($signed(t.z[v])));
      a &= c; o |= c;
    end
    keep = (ccw ? area > 0 : area < 0) && (a == 0);
    clip = (o != 0);
    mask = o;
  endtask

  task automatic drive(input tri_t t, input bit ccw);
    in_x_i = t.x; in_y_i = t.y; in_z_i = t.z;
    ccw_front_i = ccw; in_valid_i = 1'b1;
  endtask

  task automatic cmp_out(input tri_t t, input bit clip, input logic [5:0] mask,
                         input string req);
    chk(out_clip_o == clip, req, "clip flag", out_clip_o, clip);
    chk(out_planes_o == mask, req, "plane mask", out_planes_o, mask);
    chk(out_x_o == t.x && out_y_o == t.y && out_z_o == t.z, req, "vertices",
        longint'(out_x_o[0]), longint'(t.x[0]));
  endtask

  // one triangle through an idle pipe; expected values given by the caller
  task automatic run_one(input tri_t t, input bit ccw, input bit keep, input bit clip,
                         input logic [5:0] mask, input string req);
    @(negedge clk);
    chk(in_ready_o == 1'b1, req, "in_ready idle", in_ready_o, 1);
    drive(t, ccw);
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(out_valid_o == 1'b0, "R6", "early after 1 edge", out_valid_o, 0);
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R6", "early after 2 edges", out_valid_o, 0);
    @(negedge clk);
    chk(out_valid_o == keep, req, "presence", out_valid_o, keep);
    if (keep && out_valid_o) cmp_out(t, clip, mask, req);
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R6", "single beat", out_valid_o, 0);
  endtask

  task automatic t_reset;
    chk(out_valid_o == 1'b0, "R9", "out_valid after reset", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R9", "in_ready after reset", in_ready_o, 1);
  endtask

  task automatic t_facing;
    tri_t ccw_t = mk(100, 100, 200, 100, 100, 200, 10, 20, 30);
    run_one(ccw_t, 1'b1, 1, 0, 6'h00, "R1");            // area +10000, ccw front
    run_one(ccw_t, 1'b0, 0, 0, 6'h00, "R1");            // same, cw front: culled
    run_one(mk(100, 100, 100, 200, 200, 100, 1, 1, 1), 1'b0, 1, 0, 6'h00, "R1");
    run_one(mk(100, 100, 200, 200, 300, 300, 1, 1, 1), 1'b1, 0, 0, 6'h00, "R1");
    run_one(mk(100, 100, 200, 200, 300, 300, 1, 1, 1), 1'b0, 0, 0, 6'h00, "R1");
  endtask

  task automatic t_planes;
    run_one(mk(0, 0, 1023, 0, 0, 767, 0, 4095, 0), 1'b1, 1, 0, 6'h00, "R2");
    run_one(mk(0, 0, 1024, 0, 0, 767, 0, 0, 0), 1'b1, 1, 1, 6'h02, "R2");
    run_one(mk(0, -1, 1023, 0, 0, 768, -1, 0, 4096), 1'b1, 1, 1, 6'h3c, "R2");
    run_one(mk(-50, 100, 200, 100, 100, 300, 10, 10, 10), 1'b1, 1, 1, 6'h01, "R5");
    run_one(mk(-50, 100, 200, 100, 100, 300, 10, 10, 5000), 1'b1, 1, 1, 6'h21, "R5");
    run_one(mk(-10, 100, 2000, 100, 500, 900, 1, 1, 1), 1'b1, 1, 1, 6'h0b, "R5");
    run_one(mk(300, 300, 600, 300, 300, 600, 7, 8, 9), 1'b1, 1, 0, 6'h00, "R4");
  endtask

  task automatic t_reject;
    run_one(mk(1100, 100, 1200, 100, 1100, 200, 1, 1, 1), 1'b1, 0, 0, 6'h00, "R3");
    run_one(mk(-10, 800, 2000, 800, 500, 900, 1, 1, 1), 1'b1, 0, 0, 6'h00, "R3");
    run_one(mk(10, 10, 20, 10, 10, 20, -5, -6, -7), 1'b1, 0, 0, 6'h00, "R3");
    // back-facing and crossing: dropped, never routed to clip
    run_one(mk(-50, 100, 200, 100, 100, 300, 10, 10, 10), 1'b0, 0, 0, 6'h00, "R1");
  endtask

  task automatic t_burst;
    tri_t b[4];
    for (int i = 0; i < 4; i++) b[i] = mk(10 + i, 10, 100, 10, 10, 100, i, i, i);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (j < 4) drive(b[j], 1'b1); else in_valid_i = 1'b0;
      #1;
      if (j < 4) chk(in_ready_o == 1'b1, "R8", "in_ready in burst", in_ready_o, 1);
      if (j >= 3 && j <= 6) begin
        chk(out_valid_o == 1'b1, "R8", "back-to-back valid", out_valid_o, 1);
        chk(out_x_o[0] == b[j-3].x[0], "R8", "burst order", out_x_o[0], b[j-3].x[0]);
      end
    end
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R8", "burst drained", out_valid_o, 0);
  endtask

  task automatic t_stall;
    tri_t src[12];
    bit   wind[12];
    tri_t expq[$];
    bit   expc[$];
    logic [5:0] expm[$];
    bit   k, c, held;
    logic [5:0] m;
    int   idx = 0, rx = 0, cyc = 0;
    logic [5:0] h_planes;
    logic [NVERT-1:0][COORD_W-1:0] h_x;
    bit   h_clip;
    src[0]  = mk(100, 100, 200, 100, 100, 200, 1, 1, 1);  wind[0]  = 1;
    src[1]  = mk(-50, 100, 200, 100, 100, 300, 1, 1, 1);  wind[1]  = 1;
    src[2]  = mk(100, 100, 200, 100, 100, 200, 1, 1, 1);  wind[2]  = 0;
    src[3]  = mk(100, 100, 100, 200, 200, 100, 2, 2, 2);  wind[3]  = 0;
    src[4]  = mk(1100, 10, 1200, 10, 1100, 90, 1, 1, 1);  wind[4]  = 1;
    src[5]  = mk(10, 10, 900, 10, 10, 900, 1, 1, 1);      wind[5]  = 1;
    src[6]  = mk(20, 20, 60, 20, 20, 60, 3, 3, 9000);     wind[6]  = 1;
    src[7]  = mk(30, 30, 70, 30, 30, 70, 3, 3, 3);        wind[7]  = 1;
    src[8]  = mk(40, 40, 40, 80, 80, 40, 3, 3, 3);        wind[8]  = 0;
    src[9]  = mk(-5, -5, 50, 0, 0, 50, 3, 3, 3);          wind[9]  = 1;
    src[10] = mk(50, 50, 90, 50, 50, 90, 3, 3, 3);        wind[10] = 0;
    src[11] = mk(60, 60, 99, 60, 60, 99, 3, 3, 3);        wind[11] = 1;
    for (int i = 0; i < 12; i++) begin
      spec(src[i], wind[i], k, c, m);
      if (k) begin expq.push_back(src[i]); expc.push_back(c); expm.push_back(m); end
    end
    held = 0;
    while ((idx < 12 || rx < expq.size()) && cyc < 400) begin
      @(negedge clk);
      out_ready_i = (cyc % 3) != 1 && (cyc % 7) != 4;
      if (idx < 12) drive(src[idx], wind[idx]); else in_valid_i = 1'b0;
      #1;
      if (held) begin
        chk(out_valid_o && out_clip_o == h_clip && out_planes_o == h_planes && out_x_o == h_x,
            "R7", "held output stable", out_x_o[0], h_x[0]);
      end
      if (out_valid_o && !out_ready_i)
        chk(in_ready_o == 1'b0, "R7", "in_ready low on stall", in_ready_o, 0);
      held = out_valid_o && !out_ready_i;
      h_clip = out_clip_o; h_planes = out_planes_o; h_x = out_x_o;
      if (out_valid_o && out_ready_i) begin
        if (rx < expq.size()) begin
          chk(out_x_o == expq[rx].x && out_y_o == expq[rx].y && out_z_o == expq[rx].z,
              "R7", "order under stall", out_x_o[0], expq[rx].x[0]);
          chk(out_clip_o == expc[rx] && out_planes_o == expm[rx], "R5",
              "class under stall", out_planes_o, expm[rx]);
        end else begin
          chk(1'b0, "R7", "extra output", rx, expq.size());
        end
        rx++;
      end
      if (in_valid_i && in_ready_o) idx++;
      cyc++;
    end
    chk(rx == expq.size(), "R7", "outputs received", rx, expq.size());
    @(negedge clk);
    out_ready_i = 1'b1;
    in_valid_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_facing();
    t_planes();
    t_reject();
    t_burst();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule